// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Selectable Divider Clear

This block turns a 32.768 kHz clock-enable into the two time bases of a real-time clock. A binary counter of fifteen stages advances on each accepted input tick. Its full wrap gives a once-per-second pulse for the time counters, and the wrap of its lowest six stages gives a 512 Hz pulse for an interval timer. A small seconds counter (0 to 59) is driven by the once-per-second pulse. It emits a minute carry when it wraps.

Two strobes resynchronise the divider: a time-reset strobe and a 30-second-adjust strobe. A 2-bit mode register decides how much of the divider a strobe clears. In the default partial mode only the stages above the ninth are cleared, so the lower stages that feed the interval timer keep their phase, but the next 1 Hz pulse may arrive up to 15.625 ms early. In full mode (value 3) every stage is cleared. The 1 Hz phase is then exact to one input period, at the cost of slipping the interval-timer base. The strobes are decoded into one of three clear actions: CLR_NONE (count normally), CLR_UPPER (partial clear) and CLR_ALL (full clear). Each cycle takes exactly one of them. No strobe gives CLR_NONE. A strobe with mode 0, 1 or 2 gives CLR_UPPER. A strobe with mode 3 gives CLR_ALL.

Top module: `rtc_prescaler`

## Requirements
- R1: `tick_1hz` is high for exactly one cycle, in the cycle after an accepted `tick_in` that takes the whole divider count (DIV_STAGES bits, default 15) from all ones to zero.
- R2: `tick_512hz` is high for exactly one cycle, in the cycle after an accepted `tick_in` that takes the lowest TAP_STAGE bits (default 6) of the count from all ones to zero.
- R3: When `time_rst` or `adj30` is high and the mode register holds 0, 1 or 2, the count bits from LOW_STAGES upward (default bits 14..9) become zero and bits below LOW_STAGES (default 8..0) keep their value.
- R4: When `time_rst` or `adj30` is high and the mode register holds 3, the whole count becomes zero.
- R5: In a cycle where `time_rst` or `adj30` is high, `tick_in` is ignored: the count does not advance, and neither pulse output is high in the following cycle.
- R6: `seconds` advances by one in the cycle `tick_1hz` is high, counts 0 to 59, and goes from 59 to 0 with `min_carry` high for that one cycle.
- R7: `adj30` sets `seconds` to 0 and raises `min_carry` for one cycle if the value was 30 or more. `time_rst` sets `seconds` to 0 with no carry and wins over `adj30`.
- R8: The mode register loads `mode_wdata` on a cycle with `mode_we` high. A strobe in that same cycle still uses the previous mode.
- R9: A synchronous low `rst_n` zeroes the count, the seconds, the mode register and both pulse outputs and `min_carry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | 32.768 kHz clock-enable |
| time_rst | input | 1 | Time-reset strobe |
| adj30 | input | 1 | 30-second-adjust strobe |
| mode_we | input | 1 | Write enable of the mode register |
| mode_wdata | input | 2 | New mode value (3 = full clear, other = partial clear) |
| tick_1hz | output | 1 | Once-per-second pulse |
| tick_512hz | output | 1 | Interval-timer base pulse |
| seconds | output | 6 | Seconds value 0 to 59 |
| min_carry | output | 1 | Minute carry pulse |

## Verification
The assertions check on every cycle that a partial clear keeps the lower stages while zeroing the upper ones, that a full clear zeroes the count, that a strobe suppresses both pulses, that a 1 Hz pulse always coincides with a 512 Hz pulse, that seconds stay below 60 and that a carry leaves seconds at zero. What only the bench can show is the phase after a clear. It counts input ticks from a strobe to the next pulse and checks that distance against the preserved lower count. It also checks that a mode write in the same cycle as a strobe takes effect only afterwards, and that the carry rule depends on the seconds value at the adjust. A reference model run under random ticks, strobes and mode writes covers the rest.

// File: rtl/rtc_prescaler_pkg.sv
package rtc_prescaler_pkg;
    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_UPPER = 2'd1,
        CLR_ALL   = 2'd2
    } clr_kind_e;

    localparam logic [1:0] MODE_FULL_CLEAR = 2'd3;
    localparam int SEC_WIDTH = 6;
    localparam logic [SEC_WIDTH-1:0] SEC_LAST = 6'd59;
    localparam logic [SEC_WIDTH-1:0] SEC_HALF = 6'd30;
endpackage

// File: rtl/rtc_clear_ctrl.sv
module rtc_clear_ctrl
    import rtc_prescaler_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       time_rst,
    input  logic       adj30,
    input  logic       mode_we,
    input  logic [1:0] mode_wdata,
    output clr_kind_e  clr_kind
);
    logic [1:0] mode_q;
    logic       strobe;

    assign strobe = time_rst | adj30;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'd0;
        end else if (mode_we) begin
            mode_q <= mode_wdata;
        end
    end

    // Decode of the clear action uses the mode held before any write this cycle.
    always_comb begin
        if (!strobe) begin
            clr_kind = CLR_NONE;
        end else begin
            unique case (mode_q)
                MODE_FULL_CLEAR: clr_kind = CLR_ALL;
                default:         clr_kind = CLR_UPPER;
            endcase
        end
    end

    // R8: mode register holds without a write
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(mode_q));
endmodule

// File: rtl/rtc_divider_chain.sv
module rtc_divider_chain
    import rtc_prescaler_pkg::*;
#(
    parameter int DIV_STAGES = 15,
    parameter int LOW_STAGES = 9,
    parameter int TAP_STAGE  = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_in,
    input  clr_kind_e clr_kind,
    output logic      wrap_evt,
    output logic      tick_1hz,
    output logic      tick_512hz
);
    localparam int CW = DIV_STAGES;
    localparam logic [CW-1:0] LOW_MASK = CW'((64'd1 << LOW_STAGES) - 64'd1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;
    logic          accept;
    logic          tap_evt;

    assign accept   = tick_in && (clr_kind == CLR_NONE);
    assign wrap_evt = accept && (&cnt);
    assign tap_evt  = accept && (&cnt[TAP_STAGE-1:0]);

    always_comb begin
        unique case (clr_kind)
            CLR_ALL:   cnt_nx = '0;
            CLR_UPPER: cnt_nx = cnt & LOW_MASK;
            CLR_NONE:  cnt_nx = accept ? cnt + CW'(1) : cnt;
            default:   cnt_nx = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            tick_1hz   <= 1'b0;
            tick_512hz <= 1'b0;
        end else begin
            cnt        <= cnt_nx;
            tick_1hz   <= wrap_evt;
            tick_512hz <= tap_evt;
        end
    end

    p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_kind == CLR_ALL) |=> (cnt == '0));

    p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_kind == CLR_UPPER) |=> (((cnt & ~LOW_MASK) == '0) &&
                                     ((cnt & LOW_MASK) == ($past(cnt) & LOW_MASK))));

    p_pulse_nest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |-> tick_512hz);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_kind == CLR_NONE && !tick_in) |=> $stable(cnt));
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
    import rtc_prescaler_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_evt,
    input  logic                 time_rst,
    input  logic                 adj30,
    output logic [SEC_WIDTH-1:0] seconds,
    output logic                 min_carry
);
    logic [SEC_WIDTH-1:0] sec_nx;
    logic                 carry_nx;

    always_comb begin
        sec_nx   = seconds;
        carry_nx = 1'b0;
        if (time_rst) begin
            sec_nx = '0;
        end else if (adj30) begin
            sec_nx   = '0;
            carry_nx = (seconds >= SEC_HALF);
        end else if (sec_evt) begin
            if (seconds == SEC_LAST) begin
                sec_nx   = '0;
                carry_nx = 1'b1;
            end else begin
                sec_nx = seconds + SEC_WIDTH'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seconds   <= '0;
            min_carry <= 1'b0;
        end else begin
            seconds   <= sec_nx;
            min_carry <= carry_nx;
        end
    end

    p_sec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seconds <= SEC_LAST);

    p_carry_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        min_carry |-> (seconds == '0));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_prescaler_pkg::*;
#(
    parameter int DIV_STAGES = 15,
    parameter int LOW_STAGES = 9,
    parameter int TAP_STAGE  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       time_rst,
    input  logic       adj30,
    input  logic       mode_we,
    input  logic [1:0] mode_wdata,
    output logic       tick_1hz,
    output logic       tick_512hz,
    output logic [5:0] seconds,
    output logic       min_carry
);
    clr_kind_e clr_kind;
    logic      wrap_evt;

    rtc_clear_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_rst   (time_rst),
        .adj30      (adj30),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .clr_kind   (clr_kind)
    );

    rtc_divider_chain #(
        .DIV_STAGES (DIV_STAGES),
        .LOW_STAGES (LOW_STAGES),
        .TAP_STAGE  (TAP_STAGE)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .clr_kind   (clr_kind),
        .wrap_evt   (wrap_evt),
        .tick_1hz   (tick_1hz),
        .tick_512hz (tick_512hz)
    );

    rtc_seconds u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_evt   (wrap_evt),
        .time_rst  (time_rst),
        .adj30     (adj30),
        .seconds   (seconds),
        .min_carry (min_carry)
    );

    p_strobe_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (time_rst || adj30) |=> (!tick_1hz && !tick_512hz));
endmodule

// File: tb/test_rtc_prescaler.sv
module test_rtc_prescaler;
    // Reduced divider so a full minute fits in the run; the split and tap stay as in the defaults.
    localparam int DS = 10;
    localparam int LS = 9;
    localparam int TS = 6;
    localparam int CNT_MOD = 1 << DS;
    localparam int LOW_MOD = 1 << LS;
    localparam int TAP_MOD = 1 << TS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       time_rst = 1'b0;
    logic       adj30 = 1'b0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wdata = 2'd0;
    logic       tick_1hz;
    logic       tick_512hz;
    logic [5:0] seconds;
    logic       min_carry;

    int n_checks = 0;
    int n_fail = 0;

    int m_cnt = 0;
    int m_sec = 0;
    int m_mode = 0;
    bit e_1hz = 0;
    bit e_512 = 0;
    bit e_carry = 0;

    always #5 clk = ~clk;

    rtc_prescaler #(.DIV_STAGES(DS), .LOW_STAGES(LS), .TAP_STAGE(TS)) i_rtc_prescaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (tick_in),
        .time_rst   (time_rst),
        .adj30      (adj30),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .tick_1hz   (tick_1hz),
        .tick_512hz (tick_512hz),
        .seconds    (seconds),
        .min_carry  (min_carry)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic model_update();
        bit strobe;
        strobe  = time_rst || adj30;
        e_1hz   = 0;
        e_512   = 0;
        e_carry = 0;
        if (!rst_n) begin
            m_cnt = 0; m_sec = 0; m_mode = 0;
        end else begin
            if (strobe) begin
                m_cnt = (m_mode == 3) ? 0 : (m_cnt % LOW_MOD);
            end else if (tick_in) begin
                e_512 = (m_cnt % TAP_MOD) == TAP_MOD - 1;
                e_1hz = (m_cnt == CNT_MOD - 1);
                m_cnt = (m_cnt + 1) % CNT_MOD;
            end
            if (time_rst) begin
                m_sec = 0;
            end else if (adj30) begin
                e_carry = (m_sec >= 30);
                m_sec = 0;
            end else if (e_1hz) begin
                e_carry = (m_sec == 59);
                m_sec = (m_sec == 59) ? 0 : m_sec + 1;
            end
            if (mode_we) m_mode = mode_wdata;
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input bit tk, input bit tr, input bit aj, input bit we, input int wd);
        tick_in = tk; time_rst = tr; adj30 = aj; mode_we = we; mode_wdata = 2'(wd);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tick_1hz == e_1hz, "R1 tick_1hz", int'(tick_1hz), int'(e_1hz));
        check(tick_512hz == e_512, "R2 tick_512hz", int'(tick_512hz), int'(e_512));
        check(int'(seconds) == m_sec, "R6 seconds", int'(seconds), m_sec);
        check(min_carry == e_carry, "R7 min_carry", int'(min_carry), int'(e_carry));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
    endtask

    // Count accepted ticks until the chosen output pulses: 0 = 1 Hz, 1 = 512 Hz, 2 = carry.
    task automatic ticks_until(input int sel, output int n);
        bit hit;
        n = 0;
        hit = 0;
        while (!hit && n < 70000) begin
            step(1, 0, 0, 0, 0);
            n++;
            hit = (sel == 0) ? tick_1hz : (sel == 1) ? tick_512hz : min_carry;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R9: everything quiet after reset
        check(!tick_1hz && !tick_512hz && !min_carry && seconds == 6'd0,
              "R9 reset state", int'(seconds), 0);

        // R3: partial clear in mode 0 keeps the lower 9 bits (700 -> 188)
        ticks(700);
        step(0, 1, 0, 0, 0);
        ticks_until(1, n);
        check(n == 4, "R3 partial clear 512Hz phase", n, 4);
        ticks_until(0, n);
        check(n == 832, "R3 partial clear 1Hz distance", n, 832);

        // R4: full clear in mode 3 zeroes the count
        step(0, 0, 0, 1, 3);
        ticks(333);
        step(0, 0, 1, 0, 0);
        ticks_until(0, n);
        check(n == CNT_MOD, "R4 full clear 1Hz distance", n, CNT_MOD);
        ticks(77);
        step(0, 1, 0, 0, 0);
        ticks_until(1, n);
        check(n == TAP_MOD, "R4 full clear 512Hz distance", n, TAP_MOD);

        // R8: write mode 0 together with a strobe: old mode 3 applies
        ticks(500);
        step(1, 1, 0, 1, 0);
        ticks_until(0, n);
        check(n == CNT_MOD, "R8 strobe uses old mode", n, CNT_MOD);
        ticks(600);
        step(0, 1, 0, 0, 0);
        ticks_until(0, n);
        check(n == 936, "R8 new mode takes effect", n, 936);

        // R5: strobe with tick at count all-ones: tick lost, no pulse
        ticks(CNT_MOD - 1);
        step(1, 0, 1, 0, 0);
        check(!tick_1hz && !tick_512hz, "R5 tick lost on strobe", int'(tick_1hz), 0);

        // Random phase against the model, including R7 priority and mid-run resets (R9)
        for (int i = 0; i < 4000; i++) begin
            bit tk = ($urandom % 10) < 7;
            bit tr = ($urandom % 300) == 0;
            bit aj = ($urandom % 250) == 0;
            bit we = ($urandom % 400) == 0;
            int wd = $urandom % 4;
            if (($urandom % 3000) == 0) rst_n = 1'b0;
            step(tk, tr, aj, we, wd);
            rst_n = 1'b1;
        end

        // R7: adjust at 31 seconds gives a carry; R6: full minute wraps with carry
        do_reset();
        ticks(31 * CNT_MOD);
        check(seconds == 6'd31, "R6 seconds after 31 wraps", int'(seconds), 31);
        step(0, 0, 1, 0, 0);
        check(min_carry == 1'b1 && seconds == 6'd0, "R7 adjust carry at 31", int'(min_carry), 1);
        step(0, 0, 0, 0, 0);
        check(min_carry == 1'b0, "R7 carry single cycle", int'(min_carry), 0);
        ticks_until(2, n);
        check(n == 60 * CNT_MOD, "R6 minute wrap distance", n, 60 * CNT_MOD);
        // R7: time reset beats adjust, no carry
        ticks(40 * CNT_MOD / 8);
        step(0, 1, 1, 0, 0);
        check(min_carry == 1'b0 && seconds == 6'd0, "R7 time reset priority", int'(min_carry), 0);

        finish_run();
    end
endmodule